// File: doc/BRIEF.md
# Dual-Clock Mailbox Pair

This block gives two independently clocked ports a way to pass single 36-bit words to each other without going through a queue. It holds two word registers: one carries a word from port A to port B, the other from port B to port A. Each register has a pending flag. The sending port sees the flag as "full". The receiving port sees it, after synchronization, as "available".

A port accesses the block when its enable and its mailbox-select are both high. The write/read bit then picks the operation. A write stores the word into the port's outgoing mailbox, but only if that mailbox is not full. A read takes the word from the port's incoming mailbox, but only if mail is available. A read also starts the clear of the sender's flag. The set and the clear each cross between the clocks as a toggle through a two-stage synchronizer.

The single reset input is asynchronous and active low. It is released separately into each clock domain.

Top module: `dual_clk_mailbox`

## Requirements
- R1: While reset is applied, and after it is released, both full flags and both available flags read 0 and both read-data outputs read all zeros until a word is transferred.
- R2: A port write (enable=1, select=1, write=1) to an empty outgoing mailbox stores the data. The port's full output reads 1 after that port's next clock edge. A full flag never rises without such a write.
- R3: After a write into a mailbox, the receiving port's available output becomes 1 no later than four receiver clock edges after the writer's edge.
- R4: A port read (enable=1, select=1, write=0) while available=1 loads the stored word onto that port's read-data output. Available reads 0 after the same receiver clock edge.
- R5: After such a read, the sending port's full flag returns to 0 within six of the sender's clock cycles.
- R6: A write to a mailbox whose full flag is 1 is ignored. The word delivered later is the earlier, unread one.
- R7: A read while available=0 is ignored. The read-data output holds its value and no flag changes. Read data changes only on an accepted read.
- R8: An access with select=0 touches neither mailbox. Flags and read data keep their values.
- R9: The two directions work independently. Word streams sent at the same time in both directions each arrive complete and in order.
- R10: Without a read, a full flag and its matching available flag stay at 1 for any length of time.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| rst_n | input | 1 | Asynchronous active-low reset for both domains |
| a_clk | input | 1 | Port A clock |
| a_en | input | 1 | Port A access enable |
| a_write | input | 1 | Port A operation: 1 write, 0 read |
| a_sel | input | 1 | Port A mailbox select |
| a_wdata | input | 36 | Word written into the A-to-B mailbox |
| a_rdata | output | 36 | Last word read from the B-to-A mailbox |
| a_full | output | 1 | A-to-B mailbox holds unread mail |
| a_avail | output | 1 | B-to-A mailbox has mail for port A |
| b_clk | input | 1 | Port B clock |
| b_en | input | 1 | Port B access enable |
| b_write | input | 1 | Port B operation: 1 write, 0 read |
| b_sel | input | 1 | Port B mailbox select |
| b_wdata | input | 36 | Word written into the B-to-A mailbox |
| b_rdata | output | 36 | Last word read from the A-to-B mailbox |
| b_full | output | 1 | B-to-A mailbox holds unread mail |
| b_avail | output | 1 | A-to-B mailbox has mail for port B |

## Verification
The hardest case to reach from the ports is a write that arrives while the previous word is still unread. In that case the flag has crossed one way, but the clear has not yet come back. The stimulus writes a second word while full is 1 and leaves the receiver idle for many cycles. It then reads the mailbox and expects the first word. After that, both ports run send-and-receive agents at the same time on clocks of unrelated periods, so that sets and clears in the two directions overlap in many phase relations.

// File: rtl/mbx_pkg.sv
package mbx_pkg;
  localparam int unsigned MBX_DATA_W      = 36;
  localparam int unsigned MBX_SYNC_STAGES = 2;

  typedef struct packed {
    logic post;
    logic fetch;
  } mbx_acc_t;

  function automatic mbx_acc_t mbx_decode(input logic en, input logic write, input logic sel);
    mbx_acc_t acc;
    acc.post  = en & sel & write;
    acc.fetch = en & sel & ~write;
    return acc;
  endfunction
endpackage

// File: rtl/mbx_sync_bit.sv
module mbx_sync_bit #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic d,
  output logic q
);
  logic [STAGES-1:0] chain_q;
  logic [STAGES-1:0] chain_d;

  generate
    if (STAGES == 1) begin : g_single
      assign chain_d = d;
    end else begin : g_chain
      assign chain_d = {chain_q[STAGES-2:0], d};
    end
  endgenerate

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) chain_q <= '0;
    else        chain_q <= chain_d;
  end

  assign q = chain_q[STAGES-1];
endmodule

// File: rtl/mbx_post_side.sv
module mbx_post_side #(
  parameter int unsigned DATA_W      = 36,
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              post,
  input  logic [DATA_W-1:0] wdata,
  input  logic              clr_tog,
  output logic              full,
  output logic              set_tog,
  output logic [DATA_W-1:0] mbox
);
  logic              full_q, full_d;
  logic              set_tog_q, set_tog_d;
  logic              clr_seen_q, clr_seen_d;
  logic [DATA_W-1:0] mbox_q;
  logic              clr_sync;
  logic              accept;

  mbx_sync_bit #(.STAGES(SYNC_STAGES)) u_clr_sync (
    .clk   (clk),
    .rst_n (rst_n),
    .d     (clr_tog),
    .q     (clr_sync)
  );

  assign accept = post & ~full_q;

  always_comb begin
    full_d     = full_q;
    set_tog_d  = set_tog_q;
    clr_seen_d = clr_seen_q;
    if (clr_sync != clr_seen_q) begin
      clr_seen_d = clr_sync;
      full_d     = 1'b0;
    end
    if (accept) begin
      full_d    = 1'b1;
      set_tog_d = ~set_tog_q;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      full_q     <= 1'b0;
      set_tog_q  <= 1'b0;
      clr_seen_q <= 1'b0;
    end else begin
      full_q     <= full_d;
      set_tog_q  <= set_tog_d;
      clr_seen_q <= clr_seen_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      mbox_q <= '0;
    else if (accept) mbox_q <= wdata;
  end

  assign full    = full_q;
  assign set_tog = set_tog_q;
  assign mbox    = mbox_q;
endmodule

// File: rtl/mbx_fetch_side.sv
module mbx_fetch_side #(
  parameter int unsigned DATA_W      = 36,
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              fetch,
  input  logic              set_tog,
  input  logic [DATA_W-1:0] mbox,
  output logic              avail,
  output logic              clr_tog,
  output logic [DATA_W-1:0] rdata
);
  logic              avail_q, avail_d;
  logic              clr_tog_q, clr_tog_d;
  logic              set_seen_q, set_seen_d;
  logic [DATA_W-1:0] rdata_q;
  logic              set_sync;
  logic              take;

  mbx_sync_bit #(.STAGES(SYNC_STAGES)) u_set_sync (
    .clk   (clk),
    .rst_n (rst_n),
    .d     (set_tog),
    .q     (set_sync)
  );

  assign take = fetch & avail_q;

  always_comb begin
    avail_d    = avail_q;
    clr_tog_d  = clr_tog_q;
    set_seen_d = set_seen_q;
    if (set_sync != set_seen_q) begin
      set_seen_d = set_sync;
      avail_d    = 1'b1;
    end
    if (take) begin
      avail_d   = 1'b0;
      clr_tog_d = ~clr_tog_q;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      avail_q    <= 1'b0;
      clr_tog_q  <= 1'b0;
      set_seen_q <= 1'b0;
    end else begin
      avail_q    <= avail_d;
      clr_tog_q  <= clr_tog_d;
      set_seen_q <= set_seen_d;
    end
  end

  // Mailbox word is held stable by the sender while avail is set.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)    rdata_q <= '0;
    else if (take) rdata_q <= mbox;
  end

  assign avail   = avail_q;
  assign clr_tog = clr_tog_q;
  assign rdata   = rdata_q;
endmodule

// File: rtl/dual_clk_mailbox.sv
module dual_clk_mailbox
  import mbx_pkg::*;
#(
  parameter int unsigned DATA_W      = MBX_DATA_W,
  parameter int unsigned SYNC_STAGES = MBX_SYNC_STAGES
) (
  input  logic              rst_n,
  input  logic              a_clk,
  input  logic              a_en,
  input  logic              a_write,
  input  logic              a_sel,
  input  logic [DATA_W-1:0] a_wdata,
  output logic [DATA_W-1:0] a_rdata,
  output logic              a_full,
  output logic              a_avail,
  input  logic              b_clk,
  input  logic              b_en,
  input  logic              b_write,
  input  logic              b_sel,
  input  logic [DATA_W-1:0] b_wdata,
  output logic [DATA_W-1:0] b_rdata,
  output logic              b_full,
  output logic              b_avail
);
  localparam int unsigned NPORT = 2;

  logic [NPORT-1:0]  port_clk, port_rst_n, port_en, port_write, port_sel;
  logic [NPORT-1:0]  port_post, port_fetch, port_avail;
  logic [NPORT-1:0]  chan_full, chan_set_tog, chan_clr_tog;
  logic [DATA_W-1:0] port_wdata [NPORT];
  logic [DATA_W-1:0] port_rdata [NPORT];
  logic [DATA_W-1:0] chan_mbox  [NPORT];
  logic              a_rst_ok, b_rst_ok;

  assign port_clk   = {b_clk, a_clk};
  assign port_en    = {b_en, a_en};
  assign port_write = {b_write, a_write};
  assign port_sel   = {b_sel, a_sel};
  assign port_wdata[0] = a_wdata;
  assign port_wdata[1] = b_wdata;

  // Per-port reset release and access decode.
  for (genvar p = 0; p < NPORT; p++) begin : g_port
    mbx_acc_t acc;
    mbx_sync_bit #(.STAGES(SYNC_STAGES)) u_rst_sync (
      .clk   (port_clk[p]),
      .rst_n (rst_n),
      .d     (1'b1),
      .q     (port_rst_n[p])
    );
    assign acc           = mbx_decode(port_en[p], port_write[p], port_sel[p]);
    assign port_post[p]  = acc.post;
    assign port_fetch[p] = acc.fetch;
  end

  // Channel c is written by port c and read by the opposite port.
  for (genvar c = 0; c < NPORT; c++) begin : g_chan
    localparam int unsigned RD = NPORT - 1 - c;

    mbx_post_side #(.DATA_W(DATA_W), .SYNC_STAGES(SYNC_STAGES)) u_post (
      .clk     (port_clk[c]),
      .rst_n   (port_rst_n[c]),
      .post    (port_post[c]),
      .wdata   (port_wdata[c]),
      .clr_tog (chan_clr_tog[c]),
      .full    (chan_full[c]),
      .set_tog (chan_set_tog[c]),
      .mbox    (chan_mbox[c])
    );

    mbx_fetch_side #(.DATA_W(DATA_W), .SYNC_STAGES(SYNC_STAGES)) u_fetch (
      .clk     (port_clk[RD]),
      .rst_n   (port_rst_n[RD]),
      .fetch   (port_fetch[RD]),
      .set_tog (chan_set_tog[c]),
      .mbox    (chan_mbox[c]),
      .avail   (port_avail[RD]),
      .clr_tog (chan_clr_tog[c]),
      .rdata   (port_rdata[RD])
    );
  end

  assign a_full   = chan_full[0];
  assign b_full   = chan_full[1];
  assign a_avail  = port_avail[0];
  assign b_avail  = port_avail[1];
  assign a_rdata  = port_rdata[0];
  assign b_rdata  = port_rdata[1];
  assign a_rst_ok = port_rst_n[0];
  assign b_rst_ok = port_rst_n[1];
endmodule

// File: rtl/mbx_checker.sv
module mbx_checker #(
  parameter int unsigned DATA_W = 36
) (
  input logic              a_clk,
  input logic              b_clk,
  input logic              a_rst_ok,
  input logic              b_rst_ok,
  input logic              a_en,
  input logic              a_write,
  input logic              a_sel,
  input logic              a_full,
  input logic              a_avail,
  input logic [DATA_W-1:0] a_rdata,
  input logic              b_en,
  input logic              b_write,
  input logic              b_sel,
  input logic              b_full,
  input logic              b_avail,
  input logic [DATA_W-1:0] b_rdata
);
  AST_A_POST_SETS_FULL: assert property (@(posedge a_clk) disable iff (!a_rst_ok)
    (a_en && a_sel && a_write && !a_full) |=> a_full); // R2
  AST_B_POST_SETS_FULL: assert property (@(posedge b_clk) disable iff (!b_rst_ok)
    (b_en && b_sel && b_write && !b_full) |=> b_full); // R2
  AST_A_FULL_NEEDS_POST: assert property (@(posedge a_clk) disable iff (!a_rst_ok)
    $rose(a_full) |-> $past(a_en && a_sel && a_write)); // R2
  AST_B_FULL_NEEDS_POST: assert property (@(posedge b_clk) disable iff (!b_rst_ok)
    $rose(b_full) |-> $past(b_en && b_sel && b_write)); // R2
  AST_A_FETCH_CLEARS: assert property (@(posedge a_clk) disable iff (!a_rst_ok)
    (a_en && a_sel && !a_write && a_avail) |=> !a_avail); // R4
  AST_B_FETCH_CLEARS: assert property (@(posedge b_clk) disable iff (!b_rst_ok)
    (b_en && b_sel && !b_write && b_avail) |=> !b_avail); // R4
  AST_A_RDATA_HOLDS: assert property (@(posedge a_clk) disable iff (!a_rst_ok)
    !(a_en && a_sel && !a_write && a_avail) |=> $stable(a_rdata)); // R7
  AST_B_RDATA_HOLDS: assert property (@(posedge b_clk) disable iff (!b_rst_ok)
    !(b_en && b_sel && !b_write && b_avail) |=> $stable(b_rdata)); // R7
endmodule

bind dual_clk_mailbox mbx_checker #(.DATA_W(DATA_W)) u_chk (
  .a_clk    (a_clk),
  .b_clk    (b_clk),
  .a_rst_ok (a_rst_ok),
  .b_rst_ok (b_rst_ok),
  .a_en     (a_en),
  .a_write  (a_write),
  .a_sel    (a_sel),
  .a_full   (a_full),
  .a_avail  (a_avail),
  .a_rdata  (a_rdata),
  .b_en     (b_en),
  .b_write  (b_write),
  .b_sel    (b_sel),
  .b_full   (b_full),
  .b_avail  (b_avail),
  .b_rdata  (b_rdata)
);

// File: tb/sim_dual_clk_mailbox.sv
module sim_dual_clk_mailbox;
  localparam int W            = 36;
  localparam int CLK_A_PERIOD = 10;
  localparam int CLK_B_PERIOD = 14;
  localparam int NWORDS       = 12;

  logic rst_n, a_clk, b_clk;
  logic a_en, a_write, a_sel, b_en, b_write, b_sel;
  logic [W-1:0] a_wdata, b_wdata, a_rdata, b_rdata;
  logic a_full, a_avail, b_full, b_avail;

  int n_chk  = 0;
  int n_fail = 0;
  bit done   = 0;
  logic [W-1:0] q_ab[$];
  logic [W-1:0] q_ba[$];

  dual_clk_mailbox u0 (
    .rst_n(rst_n),
    .a_clk(a_clk), .a_en(a_en), .a_write(a_write), .a_sel(a_sel),
    .a_wdata(a_wdata), .a_rdata(a_rdata), .a_full(a_full), .a_avail(a_avail),
    .b_clk(b_clk), .b_en(b_en), .b_write(b_write), .b_sel(b_sel),
    .b_wdata(b_wdata), .b_rdata(b_rdata), .b_full(b_full), .b_avail(b_avail)
  );

  initial a_clk = 0;
  always #(CLK_A_PERIOD/2) a_clk = ~a_clk;
  initial b_clk = 0;
  always #(CLK_B_PERIOD/2) b_clk = ~b_clk;

  task automatic chk(input string req, input logic [W-1:0] act, input logic [W-1:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic a_drive(input logic wr, input logic sel, input logic [W-1:0] d);
    @(negedge a_clk);
    a_en = 1; a_write = wr; a_sel = sel; a_wdata = d;
    @(negedge a_clk);
    a_en = 0;
  endtask

  task automatic b_drive(input logic wr, input logic sel, input logic [W-1:0] d);
    @(negedge b_clk);
    b_en = 1; b_write = wr; b_sel = sel; b_wdata = d;
    @(negedge b_clk);
    b_en = 0;
  endtask

  // Driver tasks: push the expected word, then write it.
  task automatic a_post(input logic [W-1:0] d);
    q_ab.push_back(d);
    a_drive(1, 1, d);
  endtask

  task automatic b_post(input logic [W-1:0] d);
    q_ba.push_back(d);
    b_drive(1, 1, d);
  endtask

  function automatic logic [W-1:0] word(input int i, input int salt);
    return {4'(i + salt), 32'(i * 32'h9E37_79B9 + salt * 32'h0101_0101)};
  endfunction

  // Port A agent: monitor side pops B-to-A words, driver side sends A-to-B words.
  task automatic a_agent();
    int sent = 0;
    int got  = 0;
    while (sent < NWORDS || got < NWORDS) begin
      @(negedge a_clk);
      if (a_avail && got < NWORDS) begin
        logic [W-1:0] exp;
        a_drive(0, 1, '0);
        exp = q_ba.pop_front();
        chk("R9 B-to-A order", a_rdata, exp);
        chk("R4 A avail clear", W'(a_avail), W'(0));
        got++;
      end else if (!a_full && sent < NWORDS) begin
        a_post(word(sent, 3));
        sent++;
      end
    end
  endtask

  task automatic b_agent();
    int sent = 0;
    int got  = 0;
    while (sent < NWORDS || got < NWORDS) begin
      @(negedge b_clk);
      if (b_avail && got < NWORDS) begin
        logic [W-1:0] exp;
        b_drive(0, 1, '0);
        exp = q_ab.pop_front();
        chk("R9 A-to-B order", b_rdata, exp);
        chk("R4 B avail clear", W'(b_avail), W'(0));
        got++;
      end else if (!b_full && sent < NWORDS) begin
        b_post(word(sent, 9));
        sent++;
      end
    end
  endtask

  initial begin
    repeat (20000) @(posedge a_clk);
    if (!done) begin
      n_fail++;
      $display("FAIL watchdog: actual hung expected finished");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    logic [W-1:0] d1, d2, d3;
    int k;
    d1 = 36'hA_5A5A_0F0F;
    d2 = 36'h3_C3C3_1234;
    d3 = 36'hF_FFFF_FFFF;
    rst_n = 0;
    a_en = 0; a_write = 0; a_sel = 0; a_wdata = '0;
    b_en = 0; b_write = 0; b_sel = 0; b_wdata = '0;
    repeat (3) @(negedge b_clk);
    chk("R1 a_full in reset", W'(a_full), W'(0));
    chk("R1 b_avail in reset", W'(b_avail), W'(0));
    rst_n = 1;
    repeat (5) @(negedge b_clk);
    chk("R1 a_full", W'(a_full), W'(0));
    chk("R1 a_avail", W'(a_avail), W'(0));
    chk("R1 b_full", W'(b_full), W'(0));
    chk("R1 b_avail", W'(b_avail), W'(0));
    chk("R1 a_rdata", a_rdata, '0);
    chk("R1 b_rdata", b_rdata, '0);

    // R7: read with nothing waiting
    b_drive(0, 1, '0);
    chk("R7 b_rdata unchanged", b_rdata, '0);
    chk("R7 b_avail stays 0", W'(b_avail), W'(0));

    // R8: write with select low
    a_drive(1, 0, d2);
    chk("R8 a_full stays 0", W'(a_full), W'(0));
    repeat (8) @(negedge b_clk);
    chk("R8 b_avail stays 0", W'(b_avail), W'(0));

    // R2 / R3
    a_drive(1, 1, d1);
    chk("R2 a_full set", W'(a_full), W'(1));
    k = 0;
    while (!b_avail && k < 8) begin @(negedge b_clk); k++; end
    chk("R3 b_avail set", W'(b_avail), W'(1));
    chk("R3 latency within 4", W'(k <= 4), W'(1));

    // R6: write while full
    a_drive(1, 1, d2);
    chk("R6 a_full still 1", W'(a_full), W'(1));

    // R10: no read, flags hold
    repeat (20) @(negedge a_clk);
    chk("R10 a_full holds", W'(a_full), W'(1));
    chk("R10 b_avail holds", W'(b_avail), W'(1));

    // R8: read with select low
    b_drive(0, 0, '0);
    chk("R8 b_avail kept", W'(b_avail), W'(1));
    chk("R8 b_rdata kept", b_rdata, '0);

    // R4 / R6: read returns first word
    b_drive(0, 1, '0);
    chk("R4 R6 b_rdata first word", b_rdata, d1);
    chk("R4 b_avail cleared", W'(b_avail), W'(0));

    // R5
    k = 0;
    while (a_full && k < 10) begin @(negedge a_clk); k++; end
    chk("R5 a_full cleared", W'(a_full), W'(0));
    chk("R5 latency within 6", W'(k <= 6), W'(1));

    // R7: second read without new mail
    b_drive(0, 1, '0);
    chk("R7 b_rdata held", b_rdata, d1);

    // Mirror direction
    b_drive(1, 1, d3);
    chk("R2 b_full set", W'(b_full), W'(1));
    k = 0;
    while (!a_avail && k < 8) begin @(negedge a_clk); k++; end
    chk("R3 a_avail set", W'(a_avail), W'(1));
    chk("R3 a latency within 4", W'(k <= 4), W'(1));
    a_drive(0, 1, '0);
    chk("R4 a_rdata", a_rdata, d3);
    k = 0;
    while (b_full && k < 10) begin @(negedge b_clk); k++; end
    chk("R5 b_full cleared", W'(b_full), W'(0));

    // R9: concurrent scoreboard traffic both ways
    fork
      a_agent();
      b_agent();
    join
    chk("R9 queues drained", W'(q_ab.size() + q_ba.size()), W'(0));

    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule